// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers single-cycle event pulses from a real-time clock (periodic tick, alarm match, rejected time update) and the rising edge of a power-button input. Each event sets its own bit in a 16-bit sticky status register. A 16-bit mask register of the same layout decides which set bits may raise the single active-high interrupt line.

Software reaches both registers through a byte-wide register port, with a low and a high byte for each one. It clears flags by writing ones to two write-one-to-clear acknowledge registers, one per byte half. The button input may be asynchronous. It passes through a synchronizer chain before a rising-edge detector, and the detector keeps the previous synchronized level as state.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status register reads 0x0000, the mask register reads 0x0FFF (mask low byte 0xFF, mask high byte 0x0F) and irqOut is low.
- R2: irqOut is high exactly when at least one status bit is set whose mask bit is clear. It follows every mask write, acknowledge write and new event in the cycle after the clock edge that updates the register.
- R3: A write to address 0 replaces mask bits [7:0] only, and a write to address 1 replaces mask bits [15:8] only. Both bytes read back at those addresses.
- R4: A write of value V to address 4 clears every status bit [7:0] where V has a one. A write to address 5 does the same for status bits [15:8]. No other status bit changes.
- R5: Addresses 4 and 5 read as 0x00, and so do the unused addresses 6 and 7.
- R6: Status bits [7:0] read at address 2 and status bits [15:8] read at address 3.
- R7: A pulse on tickEvt sets status bit 8, alarmEvt sets bit 9 and updErrEvt sets bit 10, at the next clock edge.
- R8: Status bit 11 is set once per 0-to-1 transition of btnIn, seen after the synchronizer. While the button is held high, an acknowledged bit 11 stays clear.
- R9: When an event and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R10: Status bits are sticky. They clear only through an acknowledge, and writes to status addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| tickEvt | input | 1 | Periodic clock tick event pulse |
| alarmEvt | input | 1 | Alarm match event pulse |
| updErrEvt | input | 1 | Rejected time update event pulse |
| btnIn | input | 1 | Power-button level, asynchronous |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: a 0x0FFF reset mask and a two-stage button synchronizer. With these values the reset masking hides every event source until software opens the high mask byte, and the button edge lands three clock edges after the input changes. The cycle-accurate bench model reproduces that latency. With those values the bench can reach same-cycle event and acknowledge collisions, held-button re-acknowledge and half-register mask writes, under random mixes of writes, reads and events.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int STAT_W = 2 * DATA_W;

  // Event bit positions inside the status word
  localparam int TICK_BIT   = 8;
  localparam int ALARM_BIT  = 9;
  localparam int UPDERR_BIT = 10;
  localparam int BTN_BIT    = 11;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK_LO = 3'd0,
    ADR_MASK_HI = 3'd1,
    ADR_STAT_LO = 3'd2,
    ADR_STAT_HI = 3'd3,
    ADR_ACK_LO  = 3'd4,
    ADR_ACK_HI  = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic              maskLoWr;
    logic              maskHiWr;
    logic              ackLoWr;
    logic              ackHiWr;
    logic [DATA_W-1:0] wdata;
  } regStrobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STAT_W-1:0] statusQ,
  input  logic [STAT_W-1:0] maskQ,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);
  // Write decode: one strobe per writable register
  always_comb begin
    strobe          = '0;
    strobe.wdata    = wrData;
    if (wrEn) begin
      case (regAddr_e'(regAddr))
        ADR_MASK_LO: strobe.maskLoWr = 1'b1;
        ADR_MASK_HI: strobe.maskHiWr = 1'b1;
        ADR_ACK_LO:  strobe.ackLoWr  = 1'b1;
        ADR_ACK_HI:  strobe.ackHiWr  = 1'b1;
        default:     ;
      endcase
    end
  end

  // Read mux: acknowledge and unused addresses return zero
  always_comb begin
    case (regAddr_e'(regAddr))
      ADR_MASK_LO: rdData = maskQ[DATA_W-1:0];
      ADR_MASK_HI: rdData = maskQ[STAT_W-1:DATA_W];
      ADR_STAT_LO: rdData = statusQ[DATA_W-1:0];
      ADR_STAT_HI: rdData = statusQ[STAT_W-1:DATA_W];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF,
  parameter int                SYNC_LEN = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic              tickEvt,
  input  logic              alarmEvt,
  input  logic              updErrEvt,
  input  logic              btnIn,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] maskQ,
  output logic              irqOut
);
  logic [SYNC_LEN-1:0] syncQ;
  logic                btnPrevQ;
  logic                btnRise;
  logic [STAT_W-1:0]   evtVec;
  logic [STAT_W-1:0]   ackVec;

  // Button synchronizer chain
  for (genvar g = 0; g < SYNC_LEN; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ[0] <= 1'b0;
        else        syncQ[0] <= btnIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ[g] <= 1'b0;
        else        syncQ[g] <= syncQ[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) btnPrevQ <= 1'b0;
    else        btnPrevQ <= syncQ[SYNC_LEN-1];

  assign btnRise = syncQ[SYNC_LEN-1] & ~btnPrevQ;

  always_comb begin
    evtVec             = '0;
    evtVec[TICK_BIT]   = tickEvt;
    evtVec[ALARM_BIT]  = alarmEvt;
    evtVec[UPDERR_BIT] = updErrEvt;
    evtVec[BTN_BIT]    = btnRise;
  end

  always_comb begin
    ackVec = '0;
    if (strobe.ackLoWr) ackVec[DATA_W-1:0]      = strobe.wdata;
    if (strobe.ackHiWr) ackVec[STAT_W-1:DATA_W] = strobe.wdata;
  end

  // Sticky status: new events override a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) statusQ <= '0;
    else        statusQ <= (statusQ & ~ackVec) | evtVec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) maskQ <= MASK_RST;
    else begin
      if (strobe.maskLoWr) maskQ[DATA_W-1:0]      <= strobe.wdata;
      if (strobe.maskHiWr) maskQ[STAT_W-1:DATA_W] <= strobe.wdata;
    end

  assign irqOut = |(statusQ & ~maskQ);

  // R10
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.ackLoWr && !strobe.ackHiWr) |=>
      ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R9
  tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEvt |=> statusQ[TICK_BIT]);

  // R8
  btn_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ[BTN_BIT]) |-> $past(btnRise));

  // R3
  mask_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.maskLoWr && !strobe.maskHiWr) |=>
      (maskQ[STAT_W-1:DATA_W] == $past(maskQ[STAT_W-1:DATA_W])));

  // R2
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&maskQ) |-> !irqOut);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter logic [15:0] MASK_RST = 16'h0FFF,
  parameter int          SYNC_LEN = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] regAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tickEvt,
  input  logic       alarmEvt,
  input  logic       updErrEvt,
  input  logic       btnIn,
  output logic       irqOut
);
  regStrobe_t        strobe;
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] maskQ;

  irq_agg_ctrl ctrl_i (
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .strobe  (strobe),
    .rdData  (rdData)
  );

  irq_agg_dp #(.MASK_RST(MASK_RST), .SYNC_LEN(SYNC_LEN)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .tickEvt   (tickEvt),
    .alarmEvt  (alarmEvt),
    .updErrEvt (updErrEvt),
    .btnIn     (btnIn),
    .statusQ   (statusQ),
    .maskQ     (maskQ),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tickEvt = 1'b0;
  logic       alarmEvt = 1'b0;
  logic       updErrEvt = 1'b0;
  logic       btnIn = 1'b0;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Bench model
  logic [15:0] mStat = '0;
  logic [15:0] mMask = 16'h0FFF;
  logic        mS0 = 1'b0, mS1 = 1'b0, mPrev = 1'b0;
  logic        btnLvl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .tickEvt(tickEvt),
    .alarmEvt(alarmEvt), .updErrEvt(updErrEvt), .btnIn(btnIn),
    .irqOut(irqOut)
  );

  function automatic logic [7:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return mMask[7:0];
      3'd1: return mMask[15:8];
      3'd2: return mStat[7:0];
      3'd3: return mStat[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expIrq();
    return |(mStat & ~mMask);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus; model follows the register semantics
  task automatic stepCyc(logic [2:0] a, logic we, logic [7:0] d,
                         logic tk, logic al, logic er);
    logic [15:0] ack;
    logic [15:0] ev;
    regAddr = a; wrEn = we; wrData = d;
    tickEvt = tk; alarmEvt = al; updErrEvt = er; btnIn = btnLvl;
    @(posedge clk);
    ack = '0;
    if (we && a == 3'd4) ack[7:0]  = d;
    if (we && a == 3'd5) ack[15:8] = d;
    ev = '0;
    ev[8] = tk; ev[9] = al; ev[10] = er; ev[11] = mS1 & ~mPrev;
    mStat = (mStat & ~ack) | ev;
    if (we && a == 3'd0) mMask[7:0]  = d;
    if (we && a == 3'd1) mMask[15:8] = d;
    mPrev = mS1; mS1 = mS0; mS0 = btnLvl;
    @(negedge clk);
    wrEn = 1'b0; tickEvt = 1'b0; alarmEvt = 1'b0; updErrEvt = 1'b0;
    check("R2 irqOut", {15'd0, irqOut}, {15'd0, expIrq()});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) stepCyc(3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rdChk(string tag, logic [2:0] a);
    regAddr = a; wrEn = 1'b0;
    #1;
    check(tag, {8'h00, rdData}, {8'h00, expRead(a)});
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdChk("R1 mask lo", 3'd0);
    check("R1 mask lo const", {8'h00, rdData}, 16'h00FF);
    rdChk("R1 mask hi", 3'd1);
    check("R1 mask hi const", {8'h00, rdData}, 16'h000F);
    rdChk("R1 stat lo", 3'd2);
    rdChk("R1 stat hi", 3'd3);
    check("R1 irq", {15'd0, irqOut}, 16'd0);

    // R7 tick while masked: bit set, no irq
    stepCyc(3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    rdChk("R7 tick bit8", 3'd3);
    check("R7 tick const", {8'h00, rdData}, 16'h0001);
    check("R2 masked irq low", {15'd0, irqOut}, 16'd0);
    // R3 open high mask, low half untouched
    stepCyc(3'd1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R2 irq after unmask", {15'd0, irqOut}, 16'd1);
    rdChk("R3 mask lo kept", 3'd0);
    check("R3 mask lo const", {8'h00, rdData}, 16'h00FF);
    // R4 ack high clears bit 8
    stepCyc(3'd5, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    rdChk("R4 ack hi cleared", 3'd3);
    check("R4 cleared const", {8'h00, rdData}, 16'h0000);
    rdChk("R5 ack lo reads 0", 3'd4);
    rdChk("R5 ack hi reads 0", 3'd5);
    rdChk("R5 unused reads 0", 3'd7);
    // R7 alarm and update error
    stepCyc(3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    rdChk("R7 alarm err", 3'd3);
    check("R7 alarm err const", {8'h00, rdData}, 16'h0006);
    // R4 ack low leaves high bits
    stepCyc(3'd4, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    rdChk("R4 ack lo keeps hi", 3'd3);
    // R10 write to status ignored
    stepCyc(3'd3, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    rdChk("R10 stat write ignored", 3'd3);
    check("R10 const", {8'h00, rdData}, 16'h0006);
    stepCyc(3'd5, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    // R8 button edge
    btnLvl = 1'b1;
    idle(4);
    rdChk("R8 btn set", 3'd3);
    check("R8 btn const", {8'h00, rdData}, 16'h0008);
    stepCyc(3'd5, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0);
    idle(4);
    rdChk("R8 held no reset", 3'd3);
    check("R8 held const", {8'h00, rdData}, 16'h0000);
    btnLvl = 1'b0; idle(4);
    btnLvl = 1'b1; idle(4);
    rdChk("R8 second edge", 3'd3);
    // R9 event wins over same-cycle ack
    stepCyc(3'd5, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0);
    rdChk("R9 tick vs ack", 3'd3);
    check("R9 const", {8'h00, rdData[0]}, 16'h0001);
    stepCyc(3'd5, 1'b1, 8'h02, 1'b0, 1'b1, 1'b0);
    rdChk("R9 alarm vs ack", 3'd3);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 8;
      if (($urandom % 6) == 0) btnLvl = ~btnLvl;
      if (op < 6)
        stepCyc(3'(op), 1'b1, 8'($urandom),
                ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
      else if (op == 6) begin
        rdChk("R6 random read", 3'($urandom));
        idle(1);
      end else
        stepCyc(3'd0, 1'b0, 8'h00, ($urandom % 2) == 0,
                ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    for (int a = 0; a < 8; a++) rdChk("R6 final read", 3'(a));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule